// File: doc/BRIEF.md
# Main Instruction Control Decoder

This block is the purely combinational control decoder of a small pipelined load/store core. It looks at the fields of the instruction in the decode stage and at the current N, Z, C and V flags. From these it produces every select and enable the datapath needs for that instruction: where the next PC comes from, which register fields address the register file, how the immediate is extended, what the ALU does and which operand feeds its B input, and whether flags, registers or memory are written.

Four instruction classes are recognised. The first is data processing with a 4-bit command. The second is multiply, which is data processing with bit 4 set and an all-zero command. The third is a word load or store, and the fourth is branch, with or without a link write. A two-bit op field picks the class. The condition field matters only for branches. Only three conditions are supported: equal, not equal and always. Every other condition code is treated as failing.

Top module: `ctrl_decode`

## Requirements
- R1: `pc_sel` is 0 for a branch (op=2) whose condition holds. It is 2 for a register-writing data-processing instruction (op=0, not multiply, not compare) whose `rd` equals the parameter `PC_REG` (default 15). In every other case it is 1. A load or a compare naming `rd` 15 keeps `pc_sel` at 1. `pc_we` is 1 for every input.
- R2: The condition holds for code 0000 exactly when Z=1, for 0001 exactly when Z=0, and always for 1110. Every other code fails. The condition has no effect on instructions that are not branches.
- R3: `ext_sel` is 2 for branches, 1 for loads/stores (op=1) and 0 for data processing and multiply (op=0).
- R4: For data processing, `alu_op` follows the command in `funct[4:1]`: 0100 gives 0, 0010 gives 1, 1010 gives 1, 0000 gives 2, 1100 gives 3, 0001 gives 4, 1101 gives 6, and any other command gives 0. Loads and stores give 0.
- R5: Multiply is recognised when op=0, `bit4`=1 and `funct[5:1]`=0. It gives `alu_op` 7, `rn_sel` 0, `src2_sel` 1, `wa_sel` 1, `srcb_sel` 1 and `reg_we` 1. For every other instruction `rn_sel` is 1. When `funct[5:1]` is non-zero with `bit4`=1, the instruction is plain data processing.
- R6: `srcb_sel` is 1 (register operand) for multiply and for data processing with `funct[5]`=0. It is 0 (immediate) for data processing with `funct[5]`=1 and for loads, stores, branches and op=3.
- R7: `flag_we` equals `funct[0]` when op=0, covering both data processing and multiply. It is 0 for all other op values.
- R8: For op=1, `funct[0]`=0 is a store and `funct[0]`=1 is a load. A store gives `mem_we` 1, `src2_sel` 2 and `reg_we` 0. A load gives `reg_we` 1, `res_sel` 0 and `mem_we` 0. `res_sel` is 1 for all other instructions.
- R9: Branches give `alu_op` 15 and `src2_sel` 1. With `funct[4]`=1 (link), `link_sel` is 1, `wa_sel` is 2 and `reg_we` equals the condition result. Without link, `reg_we` is 0 and `link_sel` is 0.
- R10: Data processing writes the register file (`reg_we` 1) for every command except compare (1010), which gives `reg_we` 0.
- R11: op=3 writes nothing. `reg_we`, `mem_we` and `flag_we` are 0, `pc_sel` is 1 and `alu_op` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond | input | 4 | Condition field of the instruction |
| op | input | 2 | Instruction class field |
| funct | input | 6 | Immediate flag, command/link bits and S/load bit |
| rd | input | 4 | Destination register number |
| bit4 | input | 1 | Instruction bit 4, which marks multiply |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| pc_sel | output | 2 | Next-PC source: 0 branch target, 1 sequential, 2 ALU result |
| pc_we | output | 1 | PC write enable |
| rn_sel | output | 1 | First read-address select: 0 multiply field, 1 normal Rn |
| src2_sel | output | 2 | Second read-address select: 0 Rm, 1 multiply/branch field, 2 Rd for store data |
| wa_sel | output | 2 | Write-address select: 0 Rd, 1 multiply destination, 2 link register |
| reg_we | output | 1 | Register file write enable |
| ext_sel | output | 2 | Immediate extend select |
| srcb_sel | output | 1 | ALU B source: 1 register, 0 extended immediate |
| alu_op | output | 4 | ALU operation code |
| flag_we | output | 1 | Flag register write enable |
| mem_we | output | 1 | Data memory write enable |
| res_sel | output | 1 | Write-back source: 1 ALU result, 0 memory data |
| link_sel | output | 1 | Write-back data is the return address |

## Verification
Two functions can fire together in one decode. A taken branch-with-link redirects the PC and also writes the link register. A flag-setting move into register 15 redirects the PC to the ALU result and also updates the flags. The bench provokes the first case with a link branch under the equal condition, once with Z set and once with Z clear. It then requires that `pc_sel` and `reg_we` change together while `wa_sel` and `link_sel` stay fixed. It provokes the second case with a move into register 15 with and without the S bit. For both cases, each decode is judged as a whole by comparing the complete set of outputs against the expected word.

// File: rtl/ctrl_dec_pkg.sv
`timescale 1ns/1ps
package ctrl_dec_pkg;

    localparam int COND_W = 4;
    localparam int OP_W   = 2;
    localparam int FN_W   = 6;
    localparam int RA_W   = 4;
    localparam int ALU_W  = 4;
    localparam int SEL_W  = 2;
    localparam int CMD_W  = 4;
    localparam int CMD_LO = 1;
    localparam int CMD_HI = CMD_LO + CMD_W - 1;

    // instruction classes seen by the decoder
    typedef enum logic [2:0] {
        CLS_DP    = 3'd0,
        CLS_MUL   = 3'd1,
        CLS_MEM   = 3'd2,
        CLS_BR    = 3'd3,
        CLS_UNDEF = 3'd4
    } insn_class_e;

    // ALU operation codes expected by the execute stage
    typedef enum logic [ALU_W-1:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_AND   = 4'd2,
        ALU_ORR   = 4'd3,
        ALU_EOR   = 4'd4,
        ALU_PASSB = 4'd6,
        ALU_MUL   = 4'd7,
        ALU_ONE   = 4'd15
    } alu_code_e;

    typedef enum logic [SEL_W-1:0] {
        PCS_TARGET = 2'd0,
        PCS_SEQ    = 2'd1,
        PCS_RESULT = 2'd2
    } pc_src_e;

    typedef enum logic [SEL_W-1:0] {
        EXT_DP  = 2'd0,
        EXT_MEM = 2'd1,
        EXT_BR  = 2'd2
    } ext_kind_e;

    typedef enum logic [SEL_W-1:0] {
        WA_RD   = 2'd0,
        WA_MUL  = 2'd1,
        WA_LINK = 2'd2
    } wr_addr_e;

    typedef enum logic [SEL_W-1:0] {
        S2_RM  = 2'd0,
        S2_ALT = 2'd1,
        S2_RD  = 2'd2
    } src2_e;

    // op field values
    localparam logic [OP_W-1:0] OPC_DP  = 2'd0;
    localparam logic [OP_W-1:0] OPC_MEM = 2'd1;
    localparam logic [OP_W-1:0] OPC_BR  = 2'd2;

    // condition codes the decoder understands
    localparam logic [COND_W-1:0] CC_EQ = 4'b0000;
    localparam logic [COND_W-1:0] CC_NE = 4'b0001;
    localparam logic [COND_W-1:0] CC_AL = 4'b1110;

    // data-processing commands
    localparam logic [CMD_W-1:0] DPC_AND = 4'b0000;
    localparam logic [CMD_W-1:0] DPC_EOR = 4'b0001;
    localparam logic [CMD_W-1:0] DPC_SUB = 4'b0010;
    localparam logic [CMD_W-1:0] DPC_ADD = 4'b0100;
    localparam logic [CMD_W-1:0] DPC_CMP = 4'b1010;
    localparam logic [CMD_W-1:0] DPC_ORR = 4'b1100;
    localparam logic [CMD_W-1:0] DPC_MOV = 4'b1101;

endpackage

// File: rtl/ctrl_dec_cond.sv
`timescale 1ns/1ps
module ctrl_dec_cond
    import ctrl_dec_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic              flag_z,
    output logic              pass
);

    always_comb begin
        unique case (cond)
            CC_EQ:   pass = flag_z;
            CC_NE:   pass = !flag_z;
            CC_AL:   pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end

    // R2: an unsupported code can never pass
    always_comb begin
        a_r2_unknown_cond_fails: assert (pass == 1'b0 || cond == CC_EQ || cond == CC_NE || cond == CC_AL)
            else $error("unsupported condition reported as passing");
    end

endmodule

// File: rtl/ctrl_dec_class.sv
`timescale 1ns/1ps
module ctrl_dec_class
    import ctrl_dec_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [FN_W-1:0]  funct,
    input  logic             bit4,
    output insn_class_e      cls,
    output logic [CMD_W-1:0] dp_cmd,
    output logic             s_or_load,
    output logic             reg_operand,
    output logic             link_bit
);

    logic upper_zero;

    assign upper_zero  = (funct[FN_W-1:1] == '0);
    assign dp_cmd      = funct[CMD_HI:CMD_LO];
    assign s_or_load   = funct[0];
    assign reg_operand = !funct[FN_W-1];
    assign link_bit    = funct[CMD_HI];

    always_comb begin
        unique case (op)
            OPC_DP:  cls = (bit4 && upper_zero) ? CLS_MUL : CLS_DP;
            OPC_MEM: cls = CLS_MEM;
            OPC_BR:  cls = CLS_BR;
            default: cls = CLS_UNDEF;
        endcase
    end

    // R5: multiply only ever comes from op 0 with bit 4 set
    always_comb begin
        a_r5_mul_needs_bit4: assert (cls != CLS_MUL || (bit4 && op == OPC_DP))
            else $error("multiply class without its marker");
    end

endmodule

// File: rtl/ctrl_dec_alu.sv
`timescale 1ns/1ps
module ctrl_dec_alu
    import ctrl_dec_pkg::*;
(
    input  insn_class_e      cls,
    input  logic [CMD_W-1:0] dp_cmd,
    input  logic             s_bit,
    input  logic             reg_operand,
    output logic [ALU_W-1:0] alu_op,
    output logic             srcb_sel,
    output logic             flag_we,
    output logic             dp_wb
);

    always_comb begin
        alu_op   = ALU_ADD;
        srcb_sel = 1'b0;
        flag_we  = 1'b0;
        dp_wb    = 1'b0;
        unique case (cls)
            CLS_DP: begin
                srcb_sel = reg_operand;
                flag_we  = s_bit;
                dp_wb    = 1'b1;
                unique case (dp_cmd)
                    DPC_ADD: alu_op = ALU_ADD;
                    DPC_SUB: alu_op = ALU_SUB;
                    DPC_CMP: begin
                        alu_op = ALU_SUB;
                        dp_wb  = 1'b0;
                    end
                    DPC_AND: alu_op = ALU_AND;
                    DPC_ORR: alu_op = ALU_ORR;
                    DPC_EOR: alu_op = ALU_EOR;
                    DPC_MOV: alu_op = ALU_PASSB;
                    default: alu_op = ALU_ADD;
                endcase
            end
            CLS_MUL: begin
                alu_op   = ALU_MUL;
                srcb_sel = 1'b1;
                flag_we  = s_bit;
            end
            CLS_MEM: alu_op = ALU_ADD;
            CLS_BR:  alu_op = ALU_ONE;
            default: alu_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/ctrl_dec_path.sv
`timescale 1ns/1ps
module ctrl_dec_path
    import ctrl_dec_pkg::*;
#(
    parameter int unsigned PC_REG = 15
) (
    input  insn_class_e     cls,
    input  logic [RA_W-1:0] rd,
    input  logic            pass,
    input  logic            load_bit,
    input  logic            link_bit,
    input  logic            dp_wb,
    output logic [SEL_W-1:0] pc_sel,
    output logic            rn_sel,
    output logic [SEL_W-1:0] src2_sel,
    output logic [SEL_W-1:0] wa_sel,
    output logic            reg_we,
    output logic [SEL_W-1:0] ext_sel,
    output logic            mem_we,
    output logic            res_sel,
    output logic            link_sel
);

    localparam logic [RA_W-1:0] PC_IDX = RA_W'(PC_REG);

    logic hits_pc;
    assign hits_pc = (rd == PC_IDX);

    always_comb begin
        pc_sel   = PCS_SEQ;
        rn_sel   = 1'b1;
        src2_sel = S2_RM;
        wa_sel   = WA_RD;
        reg_we   = 1'b0;
        ext_sel  = EXT_DP;
        mem_we   = 1'b0;
        res_sel  = 1'b1;
        link_sel = 1'b0;
        unique case (cls)
            CLS_DP: begin
                reg_we = dp_wb;
                if (dp_wb && hits_pc) pc_sel = PCS_RESULT;
            end
            CLS_MUL: begin
                rn_sel   = 1'b0;
                src2_sel = S2_ALT;
                wa_sel   = WA_MUL;
                reg_we   = 1'b1;
            end
            CLS_MEM: begin
                ext_sel = EXT_MEM;
                if (load_bit) begin
                    reg_we  = 1'b1;
                    res_sel = 1'b0;
                end else begin
                    mem_we   = 1'b1;
                    src2_sel = S2_RD;
                end
            end
            CLS_BR: begin
                ext_sel  = EXT_BR;
                src2_sel = S2_ALT;
                if (pass) pc_sel = PCS_TARGET;
                if (link_bit) begin
                    link_sel = 1'b1;
                    wa_sel   = WA_LINK;
                    reg_we   = pass;
                end
            end
            default: ;
        endcase
    end

    // R8: a store never also writes back
    always_comb begin
        a_r8_store_no_writeback: assert (!(mem_we && reg_we))
            else $error("store decoded with a register write");
    end

endmodule

// File: rtl/ctrl_decode.sv
`timescale 1ns/1ps
module ctrl_decode
    import ctrl_dec_pkg::*;
#(
    parameter int unsigned PC_REG = 15
) (
    input  logic [3:0] cond,
    input  logic [1:0] op,
    input  logic [5:0] funct,
    input  logic [3:0] rd,
    input  logic       bit4,
    input  logic       flag_n,
    input  logic       flag_z,
    input  logic       flag_c,
    input  logic       flag_v,
    output logic [1:0] pc_sel,
    output logic       pc_we,
    output logic       rn_sel,
    output logic [1:0] src2_sel,
    output logic [1:0] wa_sel,
    output logic       reg_we,
    output logic [1:0] ext_sel,
    output logic       srcb_sel,
    output logic [3:0] alu_op,
    output logic       flag_we,
    output logic       mem_we,
    output logic       res_sel,
    output logic       link_sel
);

    insn_class_e      cls;
    logic [CMD_W-1:0] dp_cmd;
    logic             s_or_load;
    logic             reg_operand;
    logic             link_bit;
    logic             pass;
    logic             dp_wb;
    logic             unused_flags;

    // only Z takes part in the supported conditions
    assign unused_flags = flag_n ^ flag_c ^ flag_v;
    assign pc_we        = 1'b1;

    ctrl_dec_cond u_cond (
        .cond   (cond),
        .flag_z (flag_z),
        .pass   (pass)
    );

    ctrl_dec_class u_class (
        .op          (op),
        .funct       (funct),
        .bit4        (bit4),
        .cls         (cls),
        .dp_cmd      (dp_cmd),
        .s_or_load   (s_or_load),
        .reg_operand (reg_operand),
        .link_bit    (link_bit)
    );

    ctrl_dec_alu u_alu (
        .cls         (cls),
        .dp_cmd      (dp_cmd),
        .s_bit       (s_or_load),
        .reg_operand (reg_operand),
        .alu_op      (alu_op),
        .srcb_sel    (srcb_sel),
        .flag_we     (flag_we),
        .dp_wb       (dp_wb)
    );

    ctrl_dec_path #(.PC_REG(PC_REG)) u_path (
        .cls      (cls),
        .rd       (rd),
        .pass     (pass),
        .load_bit (s_or_load),
        .link_bit (link_bit),
        .dp_wb    (dp_wb),
        .pc_sel   (pc_sel),
        .rn_sel   (rn_sel),
        .src2_sel (src2_sel),
        .wa_sel   (wa_sel),
        .reg_we   (reg_we),
        .ext_sel  (ext_sel),
        .mem_we   (mem_we),
        .res_sel  (res_sel),
        .link_sel (link_sel)
    );

    // cross-checks between the ALU-side and path-side decodes
    always_comb begin
        a_r1_target_only_on_branch: assert (pc_sel != PCS_TARGET || (op == OPC_BR && pass))
            else $error("branch target chosen outside a taken branch");
        a_r7_flags_only_op0: assert (!flag_we || op == OPC_DP)
            else $error("flag write outside op 0");
        a_r9_link_with_alu15: assert (!link_sel || alu_op == ALU_ONE)
            else $error("link select without branch ALU code");
        a_r5_mul_operands: assert (rn_sel || (alu_op == ALU_MUL && srcb_sel))
            else $error("multiply read select without multiply ALU setup");
        a_r11_undef_writes_nothing: assert (op != 2'd3 || !(reg_we || mem_we || flag_we))
            else $error("undefined op produced a write");
        a_r3_ext_tracks_op: assert (op != OPC_BR || ext_sel == EXT_BR)
            else $error("branch without branch extend");
    end

endmodule

// File: tb/sim_ctrl_decode.sv
`timescale 1ns/1ps
module sim_ctrl_decode;

    localparam time CLK_HALF = 10ns;   // 50 MHz
    localparam int  WATCHDOG_CYC = 200000;

    logic       clk = 1'b0;
    logic [3:0] cond = '0;
    logic [1:0] op = '0;
    logic [5:0] funct = '0;
    logic [3:0] rd = '0;
    logic       bit4 = 1'b0;
    logic       fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;

    logic [1:0] pc_sel, src2_sel, wa_sel, ext_sel;
    logic       pc_we, rn_sel, reg_we, srcb_sel, flag_we, mem_we, res_sel, link_sel;
    logic [3:0] alu_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        logic [19:0] exp;
    } sb_item_t;

    sb_item_t sbq[$];

    always #(CLK_HALF) clk = ~clk;

    ctrl_decode u0 (
        .cond     (cond),
        .op       (op),
        .funct    (funct),
        .rd       (rd),
        .bit4     (bit4),
        .flag_n   (fn),
        .flag_z   (fz),
        .flag_c   (fc),
        .flag_v   (fv),
        .pc_sel   (pc_sel),
        .pc_we    (pc_we),
        .rn_sel   (rn_sel),
        .src2_sel (src2_sel),
        .wa_sel   (wa_sel),
        .reg_we   (reg_we),
        .ext_sel  (ext_sel),
        .srcb_sel (srcb_sel),
        .alu_op   (alu_op),
        .flag_we  (flag_we),
        .mem_we   (mem_we),
        .res_sel  (res_sel),
        .link_sel (link_sel)
    );

    // expected word: pc_sel, pc_we, rn_sel, src2_sel, wa_sel, reg_we,
    // ext_sel, srcb_sel, alu_op, flag_we, mem_we, res_sel, link_sel
    function automatic logic [19:0] pack(input int pc, input int we, input int rn,
                                         input int s2, input int wa, input int rw,
                                         input int ex, input int sb, input int alu,
                                         input int fl, input int mw, input int rs,
                                         input int lk);
        return {pc[1:0], we[0], rn[0], s2[1:0], wa[1:0], rw[0], ex[1:0],
                sb[0], alu[3:0], fl[0], mw[0], rs[0], lk[0]};
    endfunction

    // driver: apply one decode and queue its expected outputs
    task automatic apply(input string tag, input logic [3:0] c, input logic [1:0] o,
                         input logic [5:0] f, input logic [3:0] r, input logic b4,
                         input logic [3:0] nzcv, input logic [19:0] exp);
        sb_item_t it;
        @(posedge clk);
        #1;
        cond  = c;
        op    = o;
        funct = f;
        rd    = r;
        bit4  = b4;
        {fn, fz, fc, fv} = nzcv;
        it.tag = tag;
        it.exp = exp;
        sbq.push_back(it);
    endtask

    // monitor: compare at the falling edge, away from the driving edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            logic [19:0] act;
            it  = sbq.pop_front();
            act = {pc_sel, pc_we, rn_sel, src2_sel, wa_sel, reg_we, ext_sel,
                   srcb_sel, alu_op, flag_we, mem_we, res_sel, link_sel};
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %05h expected %05h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // idle input pattern (all zero): AND register, writes Rd
        apply("R4 idle and", 4'd0, 2'd0, 6'd0, 4'd0, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,0,1,2,0,0,1,0));
        // data processing commands
        apply("R4 add reg", 4'd14, 2'd0, 6'd8, 4'd3, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,0,1,0,0,0,1,0));
        apply("R4 R7 subs imm", 4'd14, 2'd0, 6'd37, 4'd2, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,0,0,1,1,0,1,0));
        apply("R10 cmp no write", 4'd14, 2'd0, 6'd21, 4'd0, 1'b0, 4'b0000,
              pack(1,1,1,0,0,0,0,1,1,1,0,1,0));
        apply("R6 and imm", 4'd14, 2'd0, 6'd32, 4'd1, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,0,0,2,0,0,1,0));
        apply("R4 orrs reg", 4'd14, 2'd0, 6'd25, 4'd1, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,0,1,3,1,0,1,0));
        apply("R4 eors imm", 4'd14, 2'd0, 6'd35, 4'd1, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,0,0,4,1,0,1,0));
        apply("R4 mov reg", 4'd14, 2'd0, 6'd26, 4'd1, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,0,1,6,0,0,1,0));
        apply("R4 other cmd", 4'd14, 2'd0, 6'd14, 4'd1, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,0,1,0,0,0,1,0));
        // writes to the PC register, with and without flag update
        apply("R1 mov to pc", 4'd14, 2'd0, 6'd58, 4'd15, 1'b0, 4'b0000,
              pack(2,1,1,0,0,1,0,0,6,0,0,1,0));
        apply("R1 R7 movs to pc", 4'd14, 2'd0, 6'd59, 4'd15, 1'b0, 4'b0000,
              pack(2,1,1,0,0,1,0,0,6,1,0,1,0));
        apply("R1 cmp rd15 stays seq", 4'd14, 2'd0, 6'd21, 4'd15, 1'b0, 4'b0000,
              pack(1,1,1,0,0,0,0,1,1,1,0,1,0));
        // multiply
        apply("R5 muls", 4'd14, 2'd0, 6'd1, 4'd4, 1'b1, 4'b0000,
              pack(1,1,0,1,1,1,0,1,7,1,0,1,0));
        apply("R5 mul", 4'd14, 2'd0, 6'd0, 4'd4, 1'b1, 4'b0000,
              pack(1,1,0,1,1,1,0,1,7,0,0,1,0));
        apply("R5 bit4 not multiply", 4'd14, 2'd0, 6'd2, 4'd4, 1'b1, 4'b0000,
              pack(1,1,1,0,0,1,0,1,4,0,0,1,0));
        // loads and stores
        apply("R8 R3 load rd15", 4'd14, 2'd1, 6'd25, 4'd15, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,1,0,0,0,0,0,0));
        apply("R8 store", 4'd14, 2'd1, 6'd24, 4'd2, 1'b0, 4'b0000,
              pack(1,1,1,2,0,0,1,0,0,0,1,1,0));
        // branches
        apply("R9 R3 branch al", 4'd14, 2'd2, 6'd32, 4'd0, 1'b0, 4'b0000,
              pack(0,1,1,1,0,0,2,0,15,0,0,1,0));
        apply("R9 branch link al", 4'd14, 2'd2, 6'd48, 4'd0, 1'b0, 4'b0000,
              pack(0,1,1,1,2,1,2,0,15,0,0,1,1));
        apply("R2 beq z1 taken", 4'd0, 2'd2, 6'd32, 4'd0, 1'b0, 4'b0100,
              pack(0,1,1,1,0,0,2,0,15,0,0,1,0));
        apply("R2 beq z0 not taken", 4'd0, 2'd2, 6'd32, 4'd0, 1'b0, 4'b1011,
              pack(1,1,1,1,0,0,2,0,15,0,0,1,0));
        apply("R2 bne z0 taken", 4'd1, 2'd2, 6'd32, 4'd0, 1'b0, 4'b0000,
              pack(0,1,1,1,0,0,2,0,15,0,0,1,0));
        apply("R2 bne z1 not taken", 4'd1, 2'd2, 6'd32, 4'd0, 1'b0, 4'b0100,
              pack(1,1,1,1,0,0,2,0,15,0,0,1,0));
        apply("R9 bleq not taken", 4'd0, 2'd2, 6'd48, 4'd0, 1'b0, 4'b0000,
              pack(1,1,1,1,2,0,2,0,15,0,0,1,1));
        apply("R9 bleq taken", 4'd0, 2'd2, 6'd48, 4'd0, 1'b0, 4'b0100,
              pack(0,1,1,1,2,1,2,0,15,0,0,1,1));
        apply("R2 code 1011 fails", 4'd11, 2'd2, 6'd32, 4'd0, 1'b0, 4'b1111,
              pack(1,1,1,1,0,0,2,0,15,0,0,1,0));
        apply("R2 code 1111 fails", 4'd15, 2'd2, 6'd32, 4'd0, 1'b0, 4'b0100,
              pack(1,1,1,1,0,0,2,0,15,0,0,1,0));
        // condition ignored outside branches
        apply("R2 failing cond on add", 4'd0, 2'd0, 6'd8, 4'd3, 1'b0, 4'b0000,
              pack(1,1,1,0,0,1,0,1,0,0,0,1,0));
        // undefined op
        apply("R11 op3 quiet", 4'd14, 2'd3, 6'd63, 4'd15, 1'b1, 4'b1111,
              pack(1,1,1,0,0,0,0,0,0,0,0,1,0));

        repeat (3) @(posedge clk);
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule